// File: doc/BRIEF.md
# Timer Compare Channel with Forced Match

This block is a single output-compare channel for a timer. Every cycle in which the count enable is high, it compares the counter value against a stored compare value. When the two are equal, it changes a waveform output pin according to a 2-bit action field. It also latches a match flag and, if clear-on-compare is selected, pulses a request to clear the counter.

A force strobe lets software apply the output action at once, without waiting for the counter. A forced action changes only the waveform pin. It leaves the flag alone, sends no clear request, and has no effect while the timer reports a PWM mode. The strobe is not stored, so its software-visible read value is always zero.

Top module: `oc_channel`

## Requirements
- R1: After reset the waveform output is 0, the match flag is 0, and the clear request is 0.
- R2: The action field `act` has four encodings: 2'b00 holds the output, 2'b01 toggles it, 2'b10 drives it to 0, and 2'b11 drives it to 1. The output changes on the clock edge that samples the triggering event.
- R3: A real match occurs when `cnt_en` is 1 and `cnt` equals `cmp`. It applies the action in `act` and sets `flag` on the next edge.
- R4: While `clr_mode` is 1, a real match drives `cnt_clr` high for exactly the one cycle after the matching edge. While `clr_mode` is 0, `cnt_clr` stays 0.
- R5: When `force_stb` is 1 and `pwm_mode` is 0, the action in `act` is applied at the next edge.
- R6: A forced action never sets `flag` and never raises `cnt_clr`, including when `clr_mode` is 1.
- R7: While `pwm_mode` is 1, `force_stb` has no effect on `wave`.
- R8: If a real match and an honoured force occur in the same cycle, the action is applied once only. A toggle therefore inverts the output a single time.
- R9: `flag` stays set until `flag_clr` is pulsed. When a clear and a match happen in the same cycle, the match wins and `flag` stays 1.
- R10: `force_rd` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt | input | W | Counter value |
| cmp | input | W | Compare value |
| cnt_en | input | 1 | Counter is ticking this cycle |
| act | input | 2 | Output action: 00 hold, 01 toggle, 10 clear, 11 set |
| clr_mode | input | 1 | This channel is TOP in clear-on-compare mode |
| pwm_mode | input | 1 | Timer is in a PWM mode |
| force_stb | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | Write-one-to-clear for the match flag |
| wave | output | 1 | Waveform output pin |
| flag | output | 1 | Match flag |
| cnt_clr | output | 1 | One-cycle counter clear request |
| force_rd | output | 1 | Read value of the force bit (always 0) |

## Verification
A wrong `wave` register shows up at the pin on the very next edge. A toggle that is applied twice in a cycle where a match and a force coincide leaves the pin unchanged, where a single toggle would have inverted it. A flag that a force has wrongly set stays visible until `flag_clr` is pulsed, so it can be seen in any later cycle. A wrong clear request shows as a `cnt_clr` pulse one cycle after the cause.

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         cnt_en,
  input  logic [1:0]   act,
  input  logic         clr_mode,
  input  logic         pwm_mode,
  input  logic         force_stb,
  input  logic         flag_clr,
  output logic         wave,
  output logic         flag,
  output logic         cnt_clr,
  output logic         force_rd
);

  logic hit, frc, fire, wave_nx;

  assign hit      = cnt_en && (cnt == cmp);
  assign frc      = force_stb && !pwm_mode;
  assign fire     = hit || frc;
  assign force_rd = 1'b0;

  always_comb begin
    case (act)
      2'b01:   wave_nx = ~wave;
      2'b10:   wave_nx = 1'b0;
      2'b11:   wave_nx = 1'b1;
      default: wave_nx = wave;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave    <= 1'b0;
      flag    <= 1'b0;
      cnt_clr <= 1'b0;
    end else begin
      if (fire) wave <= wave_nx;
      if (hit) flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      cnt_clr <= hit && clr_mode;
    end
  end

  AST_CLR_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_clr) |-> $past(cnt_en && cnt == cmp && clr_mode)); // R4
  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !(cnt_en && cnt == cmp) && !flag) |=> !flag); // R6
  AST_PWM_BLOCKS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !(cnt_en && cnt == cmp)) |=> $stable(wave)); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag); // R9
  AST_FORCE_RD_ZERO: assert property (@(posedge clk) force_rd == 1'b0); // R10
  AST_SINGLE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'b01 && force_stb && !pwm_mode && cnt_en && cnt == cmp) |=> (wave != $past(wave))); // R8

endmodule

// File: tb/sim_oc_channel.sv
module sim_oc_channel;
  localparam int W = 8;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] cnt = 0, cmp = 0;
  logic cnt_en = 0, clr_mode = 0, pwm_mode = 0, force_stb = 0, flag_clr = 0;
  logic [1:0] act = 0;
  logic wave, flag, cnt_clr, force_rd;

  int n_chk = 0, n_bad = 0;
  logic m_wave, m_flag, m_clr;

  always #(PERIOD/2) clk = ~clk;

  oc_channel #(.W(W)) u0 (.clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(cmp), .cnt_en(cnt_en),
    .act(act), .clr_mode(clr_mode), .pwm_mode(pwm_mode), .force_stb(force_stb),
    .flag_clr(flag_clr), .wave(wave), .flag(flag), .cnt_clr(cnt_clr), .force_rd(force_rd));

  function automatic logic act_of(input logic [1:0] a, input logic w);
    case (a)
      2'b01: return ~w;
      2'b10: return 1'b0;
      2'b11: return 1'b1;
      default: return w;
    endcase
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step();
    logic hit, frc;
    hit = cnt_en && cnt == cmp;
    frc = force_stb && !pwm_mode;
    @(posedge clk);
    if (hit || frc) m_wave = act_of(act, m_wave);
    if (hit) m_flag = 1;
    else if (flag_clr) m_flag = 0;
    m_clr = hit && clr_mode;
    #(PERIOD/4);
    chk("R2/R3/R5/R7/R8 wave", wave, m_wave);
    chk("R3/R6/R9 flag", flag, m_flag);
    chk("R4/R6 cnt_clr", cnt_clr, m_clr);
    chk("R10 force_rd", force_rd, 1'b0);
  endtask

  task automatic drive(input logic [W-1:0] c, input logic [W-1:0] k, input logic en,
                       input logic [1:0] a, input logic cm, input logic pm,
                       input logic fs, input logic fc);
    cnt = c; cmp = k; cnt_en = en; act = a; clr_mode = cm; pwm_mode = pm;
    force_stb = fs; flag_clr = fc;
    step();
  endtask

  initial begin
    #(PERIOD*5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #(PERIOD/4);
    rst_n = 1;
    m_wave = 0; m_flag = 0; m_clr = 0;
    chk("R1 wave", wave, 0); chk("R1 flag", flag, 0); chk("R1 cnt_clr", cnt_clr, 0);
    // R5 R6: set by force in clear mode, no flag, no clear
    drive(1, 9, 1, 2'b11, 1, 0, 1, 0);
    chk("R5 forced set", wave, 1); chk("R6 no flag", flag, 0); chk("R6 no clr", cnt_clr, 0);
    // R7: force ignored in PWM
    drive(1, 9, 1, 2'b10, 0, 1, 1, 0);
    chk("R7 pwm ignores force", wave, 1);
    // R8: match and force toggle together
    drive(5, 5, 1, 2'b01, 1, 0, 1, 0);
    chk("R8 single toggle", wave, 0); chk("R3 flag set", flag, 1); chk("R4 clr pulse", cnt_clr, 1);
    drive(5, 6, 1, 2'b00, 1, 0, 0, 0);
    chk("R4 one cycle", cnt_clr, 0); chk("R9 flag held", flag, 1);
    // R9: clear and match together keep flag
    drive(3, 3, 1, 2'b00, 0, 0, 0, 1);
    chk("R9 match wins", flag, 1);
    drive(3, 4, 1, 2'b00, 0, 0, 0, 1);
    chk("R9 cleared", flag, 0);
    // R3: equal but not enabled is no match
    drive(7, 7, 0, 2'b11, 1, 0, 0, 0);
    chk("R3 no enable", flag, 0); chk("R2 held", wave, 0);
    for (int i = 0; i < 2000; i++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1),
            2'($urandom), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1), ($urandom_range(0, 3) == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule